// File: doc/BRIEF.md
# Multithreaded Issue-Queue Entry Allocator

This block keeps the occupancy bookkeeping for a shared instruction issue queue in a core that runs several hardware threads at once. It holds no instruction payloads. It keeps a pool-wide count of free slots and an occupancy count for each thread. From these it tells the dispatch stage, every cycle, whether the whole queue is exhausted, whether each thread has reached its own cap, and how many more slots each thread may claim.

A static configuration input picks how the queue is shared among threads. In the open policy any thread may use every slot. In the split policy the queue is divided evenly among the currently active threads. In the capped policy each thread is limited to a fixed percentage of the queue, unless exactly one thread is active, in which case that thread may use all of it. The caps follow the active-thread mask and the policy input combinationally, so a change to either takes effect in the same cycle.

Dispatch requests and three kinds of release pulse arrive each cycle, each tagged with a thread number. Releases come from the issue of a non-memory instruction, from the completion of a memory instruction, and from the squash of an entry that was still held. The caller decides which event frees an entry. The block applies all events of a cycle in one update.

Top module: `iq_alloc`

## Requirements
- R1: After reset every thread occupancy is zero, `queue_free` equals NUM_ENTRIES, `queue_full` is low, and every `thread_free` equals that thread's current cap.
- R2: With `policy_sel` = 2'b00 (open), and also for the unused code 2'b11, every thread's cap is NUM_ENTRIES.
- R3: With `policy_sel` = 2'b01 (split), every thread's cap is floor(NUM_ENTRIES / k), where k is the number of set bits in `active_mask`. When no bit is set, k is taken as NUM_THREADS.
- R4: With `policy_sel` = 2'b10 (capped), every thread's cap is floor(NUM_ENTRIES * CAP_PCT / 100). When exactly one bit of `active_mask` is set, the thread on that bit gets NUM_ENTRIES instead.
- R5: `thread_free[t]` (field t is bits t*CW to t*CW+CW-1, where CW = clog2(NUM_ENTRIES+1)) equals the cap minus the occupancy, or zero if the occupancy is at or above the cap. `thread_full[t]` is high exactly when that value is zero.
- R6: An accepted dispatch raises the tagged thread's occupancy by one and lowers `queue_free` by one at the next clock edge.
- R7: A dispatch is rejected when the tagged thread is full or `queue_full` is high, judged on the state before any release in the same cycle. `disp_reject` goes high in that same cycle, and the dispatch changes no count.
- R8: Each release pulse (issue, memory completion, squash) lowers the tagged thread's occupancy by one and raises `queue_free` by one. Pulses that coincide with each other and with a dispatch are all applied at the same edge.
- R9: Any release that would take a thread's occupancy below zero, counting a same-cycle accepted dispatch, is ignored and leaves all counts unchanged.
- R10: `queue_free` always equals NUM_ENTRIES minus the sum of the thread occupancies, and `queue_full` is high exactly when `queue_free` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Sharing policy: 00 open, 01 split, 10 capped, 11 open |
| active_mask | input | NUM_THREADS | One bit per active thread |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | TW | Thread of the dispatch |
| iss_rel_valid | input | 1 | Release on issue of a non-memory instruction |
| iss_rel_tid | input | TW | Thread of the issue release |
| mem_rel_valid | input | 1 | Release on memory-instruction completion |
| mem_rel_tid | input | TW | Thread of the memory release |
| sq_rel_valid | input | 1 | Release of a squashed held entry |
| sq_rel_tid | input | TW | Thread of the squash release |
| disp_reject | output | 1 | Dispatch refused this cycle |
| queue_full | output | 1 | No free slot left in the queue |
| queue_free | output | CW | Free slots in the whole queue |
| thread_full | output | NUM_THREADS | Per-thread cap reached |
| thread_free | output | NUM_THREADS*CW | Per-thread free count, packed |

## Verification
The in-design assertions check, on every cycle, the conservation rule between the pool-wide free count and the thread occupancies. They also check the occupancy bound, the one-step effect of an isolated accepted dispatch, the frozen state after an isolated rejected dispatch, and that a release to an empty thread leaves it empty. The cap arithmetic of the three policies across every active-mask pattern can only be shown by the bench's sweep against its own computed caps. The same holds for the cases where the split cap shrinks below a thread's occupancy, and for long mixed sequences of coincident dispatches and releases.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
   typedef enum logic [1:0] {
      POL_OPEN  = 2'b00,
      POL_SPLIT = 2'b01,
      POL_CAP   = 2'b10,
      POL_SPARE = 2'b11
   } iqa_policy_e;
endpackage

// File: rtl/iqa_limit_calc.sv
module iqa_limit_calc
   import iqa_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int NUM_ENTRIES = 16,
   parameter int CAP_PCT     = 75,
   localparam int CW  = $clog2(NUM_ENTRIES + 1),
   localparam int KW  = $clog2(NUM_THREADS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                policy_sel,
   input  logic [NUM_THREADS-1:0]    active_mask,
   output logic [NUM_THREADS*CW-1:0] limits
);
   localparam int CAP_VAL = (NUM_ENTRIES * CAP_PCT) / 100;

   logic [CW-1:0] split_tab [0:NUM_THREADS];
   logic [KW-1:0] act_cnt;
   logic [CW-1:0] split_val;

   // Quotient table for the split policy, one entry per active-thread count.
   for (genvar k = 0; k <= NUM_THREADS; k++) begin : g_split
      if (k == 0) begin : g_none
         assign split_tab[k] = CW'(NUM_ENTRIES / NUM_THREADS);
      end else begin : g_some
         assign split_tab[k] = CW'(NUM_ENTRIES / k);
      end
   end

   always_comb begin
      act_cnt = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         act_cnt = act_cnt + KW'(active_mask[t]);
      end
   end

   assign split_val = split_tab[act_cnt];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lim
      always_comb begin
         unique case (iqa_policy_e'(policy_sel))
            POL_SPLIT: limits[t*CW +: CW] = split_val;
            POL_CAP:   limits[t*CW +: CW] = (act_cnt == KW'(1) && active_mask[t])
                                            ? CW'(NUM_ENTRIES) : CW'(CAP_VAL);
            default:   limits[t*CW +: CW] = CW'(NUM_ENTRIES);
         endcase
      end

      // R2: the open policy never caps a thread below the queue size
      a_r2_open_full_cap: assert property (@(posedge clk) disable iff (!rst_n)
         (policy_sel == 2'b00) |-> (limits[t*CW +: CW] == CW'(NUM_ENTRIES)));
      // R3/R4: no cap exceeds the queue size
      a_r3_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
         limits[t*CW +: CW] <= CW'(NUM_ENTRIES));
   end
endmodule

// File: rtl/iqa_thread_ctr.sv
module iqa_thread_ctr #(
   parameter int NUM_ENTRIES = 16,
   localparam int CW = $clog2(NUM_ENTRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic [1:0]    rel_req,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] occ,
   output logic [CW-1:0] free_cnt,
   output logic          full,
   output logic [1:0]    rel_eff
);
   logic [CW:0] avail;
   logic [CW:0] occ_nxt;

   assign avail   = {1'b0, occ} + (CW+1)'(inc);
   assign rel_eff = ({{(CW-1){1'b0}}, rel_req} > avail) ? avail[1:0] : rel_req;
   assign occ_nxt = avail - (CW+1)'(rel_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ_nxt[CW-1:0];
   end

   assign free_cnt = (limit > occ) ? (limit - occ) : '0;
   assign full     = (free_cnt == '0);

   // R5: occupancy never exceeds the queue size
   a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(NUM_ENTRIES));
   // R9: a release to an empty thread with no dispatch leaves it empty
   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0 && !inc && rel_req != 2'd0) |=> (occ == '0));
   // R6: an isolated dispatch grows occupancy by exactly one
   a_r6_single_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && rel_req == 2'd0) |=> (occ == $past(occ) + CW'(1)));
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc
   import iqa_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int NUM_ENTRIES = 16,
   parameter int CAP_PCT     = 75,
   localparam int CW = $clog2(NUM_ENTRIES + 1),
   localparam int TW = $clog2(NUM_THREADS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                policy_sel,
   input  logic [NUM_THREADS-1:0]    active_mask,
   input  logic                      disp_valid,
   input  logic [TW-1:0]             disp_tid,
   input  logic                      iss_rel_valid,
   input  logic [TW-1:0]             iss_rel_tid,
   input  logic                      mem_rel_valid,
   input  logic [TW-1:0]             mem_rel_tid,
   input  logic                      sq_rel_valid,
   input  logic [TW-1:0]             sq_rel_tid,
   output logic                      disp_reject,
   output logic                      queue_full,
   output logic [CW-1:0]             queue_free,
   output logic [NUM_THREADS-1:0]    thread_full,
   output logic [NUM_THREADS*CW-1:0] thread_free
);
   localparam int SW = CW + TW + 2;

   if (NUM_THREADS < 2 || (1 << TW) != NUM_THREADS) begin : g_bad_threads
      $error("NUM_THREADS must be a power of two and at least 2");
   end
   if (NUM_ENTRIES < NUM_THREADS) begin : g_bad_entries
      $error("NUM_ENTRIES must be at least NUM_THREADS");
   end
   if (CAP_PCT < 1 || CAP_PCT > 100) begin : g_bad_pct
      $error("CAP_PCT must lie in 1..100");
   end

   logic [NUM_THREADS*CW-1:0] limits;
   logic [CW-1:0]             occ     [NUM_THREADS];
   logic [1:0]                rel_eff [NUM_THREADS];
   logic [NUM_THREADS-1:0]    inc_vec;
   logic                      disp_ok;
   logic [TW+1:0]             rel_total;
   logic [SW-1:0]             occ_sum;
   logic [CW-1:0]             gfree_q;
   logic                      any_rel;

   iqa_limit_calc #(
      .NUM_THREADS (NUM_THREADS),
      .NUM_ENTRIES (NUM_ENTRIES),
      .CAP_PCT     (CAP_PCT)
   ) u_lim (
      .clk         (clk),
      .rst_n       (rst_n),
      .policy_sel  (policy_sel),
      .active_mask (active_mask),
      .limits      (limits)
   );

   assign queue_full  = (gfree_q == '0);
   assign disp_ok     = disp_valid && !queue_full && !thread_full[disp_tid];
   assign disp_reject = disp_valid && !disp_ok;
   assign any_rel     = iss_rel_valid || mem_rel_valid || sq_rel_valid;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [1:0] rel_req;
      assign inc_vec[t] = disp_ok && (disp_tid == TW'(t));
      assign rel_req = 2'(iss_rel_valid && iss_rel_tid == TW'(t))
                     + 2'(mem_rel_valid && mem_rel_tid == TW'(t))
                     + 2'(sq_rel_valid  && sq_rel_tid  == TW'(t));

      iqa_thread_ctr #(
         .NUM_ENTRIES (NUM_ENTRIES)
      ) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc      (inc_vec[t]),
         .rel_req  (rel_req),
         .limit    (limits[t*CW +: CW]),
         .occ      (occ[t]),
         .free_cnt (thread_free[t*CW +: CW]),
         .full     (thread_full[t]),
         .rel_eff  (rel_eff[t])
      );
   end

   always_comb begin
      rel_total = '0;
      occ_sum   = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         rel_total = rel_total + (TW+2)'(rel_eff[t]);
         occ_sum   = occ_sum + SW'(occ[t]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gfree_q <= CW'(NUM_ENTRIES);
      else        gfree_q <= CW'(SW'(gfree_q) + SW'(rel_total) - SW'(disp_ok));
   end

   assign queue_free = gfree_q;

   // R10: pool-wide free count balances the thread occupancies
   a_r10_conserve: assert property (@(posedge clk) disable iff (!rst_n)
      (SW'(gfree_q) + occ_sum) == SW'(NUM_ENTRIES));
   // R7: a refused dispatch with no release leaves the pool count alone
   a_r7_reject_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_reject && !any_rel) |=> $stable(gfree_q));
   // R6: an accepted dispatch with no release takes exactly one slot
   a_r6_accept_take: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_reject && !any_rel) |=> (gfree_q == $past(gfree_q) - CW'(1)));
   // R7: no dispatch is accepted into an exhausted queue
   a_r7_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && queue_full) |-> disp_reject);
endmodule

// File: tb/sim_iq_alloc.sv
module sim_iq_alloc;
   localparam int CLK_P = 10;
   localparam int NT = 4;
   localparam int NE = 16;
   localparam int PCT = 75;
   localparam int CW = 5;
   localparam int TW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] pol = 2'b00;
   logic [NT-1:0] msk = '1;
   logic dv = 0, iv = 0, mv = 0, sv = 0;
   logic [TW-1:0] dt = 0, it = 0, mt = 0, st = 0;
   logic disp_reject, queue_full;
   logic [CW-1:0] queue_free;
   logic [NT-1:0] thread_full;
   logic [NT*CW-1:0] thread_free;

   int n_chk = 0, n_bad = 0;
   int occ_m [NT];
   logic [31:0] rng = 32'h1234_5677;

   always #(CLK_P/2) clk = ~clk;

   iq_alloc #(.NUM_THREADS(NT), .NUM_ENTRIES(NE), .CAP_PCT(PCT)) u0 (
      .clk(clk), .rst_n(rst_n), .policy_sel(pol), .active_mask(msk),
      .disp_valid(dv), .disp_tid(dt), .iss_rel_valid(iv), .iss_rel_tid(it),
      .mem_rel_valid(mv), .mem_rel_tid(mt), .sq_rel_valid(sv), .sq_rel_tid(st),
      .disp_reject(disp_reject), .queue_full(queue_full), .queue_free(queue_free),
      .thread_full(thread_full), .thread_free(thread_free));

   function automatic int lim_m(int p, logic [NT-1:0] m, int t);
      int c = $countones(m);
      if (p == 1) return (c == 0) ? NE / NT : NE / c;
      if (p == 2) return (c == 1 && m[t]) ? NE : (NE * PCT) / 100;
      return NE;
   endfunction

   function automatic int gfree_m();
      int s = NE;
      for (int t = 0; t < NT; t++) s -= occ_m[t];
      return s;
   endfunction

   function automatic int tfree_m(int t);
      int l = lim_m(int'(pol), msk, t);
      return (l > occ_m[t]) ? l - occ_m[t] : 0;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag);
      for (int t = 0; t < NT; t++) begin
         chk(int'(thread_free[t*CW +: CW]) == tfree_m(t), {tag, " R5 thread_free"},
             int'(thread_free[t*CW +: CW]), tfree_m(t));
         chk(thread_full[t] == (tfree_m(t) == 0), {tag, " R5 thread_full"},
             int'(thread_full[t]), int'(tfree_m(t) == 0));
      end
      chk(int'(queue_free) == gfree_m(), {tag, " R10 queue_free"}, int'(queue_free), gfree_m());
      chk(queue_full == (gfree_m() == 0), {tag, " R10 queue_full"}, int'(queue_full),
          int'(gfree_m() == 0));
   endtask

   // One cycle: drive at negedge, check refusal before the edge, state after.
   task automatic step(bit d, int dtid, bit i, int itid, bit m, int mtid,
                       bit s, int stid, string tag);
      int free_now [NT];
      bit acc;
      int rel;
      int avail;
      @(negedge clk);
      dv = d; dt = TW'(dtid); iv = i; it = TW'(itid);
      mv = m; mt = TW'(mtid); sv = s; st = TW'(stid);
      #1;
      for (int t = 0; t < NT; t++) free_now[t] = tfree_m(t);
      acc = d && free_now[dtid] != 0 && gfree_m() != 0;
      chk(disp_reject == (d && !acc), {tag, " R7 disp_reject"}, int'(disp_reject),
          int'(d && !acc));
      @(posedge clk);
      #1;
      for (int t = 0; t < NT; t++) begin
         avail = occ_m[t] + ((acc && dtid == t) ? 1 : 0);
         rel = ((i && itid == t) ? 1 : 0) + ((m && mtid == t) ? 1 : 0)
             + ((s && stid == t) ? 1 : 0);
         if (rel > avail) rel = avail; // R9
         occ_m[t] = avail - rel;
      end
      dv = 0; iv = 0; mv = 0; sv = 0;
      chk_state(tag);
   endtask

   function automatic logic [31:0] nxt(logic [31:0] x);
      logic [31:0] y = x;
      y ^= y << 13; y ^= y >> 17; y ^= y << 5;
      return y;
   endfunction

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int t = 0; t < NT; t++) occ_m[t] = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk_state("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1 after release");

      // R2 R3 R4: cap sweep over every policy code and mask with empty queue
      for (int p = 0; p < 4; p++) begin
         for (int mm = 0; mm < 16; mm++) begin
            @(negedge clk);
            pol = 2'(p); msk = NT'(mm);
            #1;
            for (int t = 0; t < NT; t++) begin
               chk(int'(thread_free[t*CW +: CW]) == lim_m(p, NT'(mm), t),
                   (p == 1) ? "R3 split cap" : (p == 2) ? "R4 capped cap" : "R2 open cap",
                   int'(thread_free[t*CW +: CW]), lim_m(p, NT'(mm), t));
            end
         end
      end

      // R6 R7: split among two threads, fill thread 0 to its cap of 8
      @(negedge clk); pol = 2'b01; msk = 4'b0011;
      for (int k = 0; k < 9; k++) step(1, 0, 0, 0, 0, 0, 0, 0, "R6 fill");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R7 thread cap");
      // R9: release to an empty thread is ignored
      step(0, 0, 0, 0, 1, 3, 0, 0, "R9 empty release");
      step(0, 0, 1, 2, 0, 0, 1, 2, "R9 double empty");
      // R8: three releases and a dispatch at the same edge
      step(1, 1, 1, 0, 1, 0, 1, 0, "R8 coincident");
      step(1, 2, 1, 2, 0, 0, 0, 0, "R8 dispatch+release same thread");
      // R3: cap shrinks below occupancy when all threads become active
      @(negedge clk); msk = 4'b1111;
      #1; chk_state("R3 shrink");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R7 over cap");
      // R4: single active thread owns whole queue under capped policy
      @(negedge clk); pol = 2'b10; msk = 4'b0001;
      #1; chk_state("R4 solo");
      // R7 R10: open policy, exhaust the queue through thread 1
      @(negedge clk); pol = 2'b00; msk = 4'b1111;
      for (int k = 0; k < 14; k++) step(1, 1, 0, 0, 0, 0, 0, 0, "R10 fill");
      step(1, 2, 0, 0, 0, 0, 0, 0, "R7 queue full");
      step(1, 2, 0, 0, 1, 1, 0, 0, "R7 full with release");

      // Mixed traffic under every policy and several masks
      for (int seg = 0; seg < 8; seg++) begin
         @(negedge clk); pol = 2'(seg % 4); msk = NT'(seg * 5 + 3);
         for (int k = 0; k < 150; k++) begin
            rng = nxt(rng);
            step(rng[0] | rng[1], int'(rng[3:2]), rng[4] & rng[5], int'(rng[7:6]),
                 rng[8] & rng[9], int'(rng[11:10]), rng[12] & rng[13] & rng[14],
                 int'(rng[16:15]), "R8 mixed");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule